// File: doc/BRIEF.md
# Trap Level Controller with Hypervisor Routing

This block sits beside a processor's trap logic. It decides where each trap is delivered and keeps the trap stack up to date. A trap request arrives with a trap type, the privilege level the trap was raised from and the current hyperprivileged state word. The controller uses its own trap-level counter and picks one of four destinations: the reset/error (RED) state, an error stop, a hyperprivileged vector or a privileged vector. It reports the vector selector and the new trap level one cycle later. Every trap except an error stop saves the caller's PC, next PC, state word and hyperprivileged state in the stack slot for the new level.

A done/retry return request reads the slot at the current level. It hands back the address space identifier, condition codes, global level and hyperprivileged state saved there. It also returns the next PC, taken from the saved PC, and the next-next PC, taken from the saved next PC. It then lowers the trap level by one. Vector address arithmetic and instruction fetch belong to the surrounding pipeline.

The checks follow a fixed priority. RED/near-limit comes first, then the error stop at the limit, then the guest watchdog, then the hyperprivileged route, and last the privileged default. The trap-level limit `MAX_TL` and the privileged limit `MAX_PTL` are parameters.

Top module: `tlc_trap_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `tl` = 0, `trap_vld` = 0 and `ret_vld` = 0.
- R2: A trap is routed RED (`trap_dest` = 2) with `trap_vec` = 5 when bit 5 of `hpstate` is set or when `tl` = `MAX_TL`-1. The RED route wins over every other route. A RED entry taken with `tl` = `MAX_TL` leaves `tl` at `MAX_TL` and overwrites the top slot.
- R3: A trap with `tl` = `MAX_TL` and bit 5 of `hpstate` clear is an error stop. It gives `trap_dest` = 3 and `trap_vec` = 0, leaves `tl` unchanged and writes no stack slot.
- R4: A trap raised from privileged level (`priv_lvl` = 1) with `MAX_PTL` < `tl` (and no RED or error condition) is a guest watchdog. It gives `trap_dest` = 1 and `trap_vec` = 2. When `tl` = `MAX_PTL` this route is not taken.
- R5: A trap raised from hyperprivileged level (`priv_lvl` = 2 or 3), or from privileged level with a trap type of 384 or more, goes to `trap_dest` = 1 with `trap_vec` equal to the trap type. At privileged level a trap type of 383 does not take this route.
- R6: Every other trap goes to `trap_dest` = 0 with `trap_vec` equal to the trap type. This includes user level (`priv_lvl` = 0) with any trap type.
- R7: Trap results appear on `trap_vld`, `trap_dest`, `trap_vec` and `tl` in the cycle after `trap_req`. Every trap other than an error stop raises `tl` by one, with the saturation of R2 as the one exception.
- R8: Each trap other than an error stop stores `cur_pc`, `cur_npc`, `cur_tstate` and `hpstate` in the stack slot for the new trap level.
- R9: A return with `tl` > 0 sets `ret_vld` in the next cycle. From the slot at the current `tl` it gives `ret_asi` = saved state bits 31:24, `ret_ccr` = bits 39:32, `ret_gl` = bits 42:40, `ret_hpstate` = the saved hyperprivileged state, `ret_npc` = the saved PC and `ret_nnpc` = the saved next PC. It then lowers `tl` by one.
- R10: A return request with `tl` = 0 is ignored: `ret_vld` stays 0 and `tl` stays 0.
- R11: When `trap_req` and `ret_req` arrive in the same cycle, the trap is taken and the return is dropped (`ret_vld` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap request pulse |
| trap_type | input | TTW | Trap type number |
| priv_lvl | input | 2 | Level the trap is raised from: 0 user, 1 privileged, 2/3 hyperprivileged |
| hpstate | input | HPW | Current hyperprivileged state; bit 5 requests RED entry |
| cur_pc | input | PCW | PC to save on a trap |
| cur_npc | input | PCW | Next PC to save on a trap |
| cur_tstate | input | TSW | State word to save on a trap |
| ret_req | input | 1 | Done/retry return request |
| tl | output | TLW | Current trap level |
| trap_vld | output | 1 | Trap result valid |
| trap_dest | output | 2 | 0 privileged, 1 hyperprivileged, 2 RED, 3 error stop |
| trap_vec | output | TTW | Vector selector |
| ret_vld | output | 1 | Return result valid |
| ret_asi | output | 8 | Restored address space identifier |
| ret_ccr | output | 8 | Restored condition codes |
| ret_gl | output | 3 | Restored global level |
| ret_hpstate | output | HPW | Restored hyperprivileged state |
| ret_npc | output | PCW | Next PC after return (saved PC) |
| ret_nnpc | output | PCW | Next-next PC after return (saved next PC) |

## Verification
The bench steps through every route at the levels where the routes hand over. It uses `tl` equal to `MAX_PTL`, which must not raise a watchdog, one level above it, which must, and `MAX_TL`-1 and `MAX_TL`, which split RED from the error stop. A design with an off-by-one limit compare would send those traps to the wrong destination. Trap types 383 and 384 at privileged level, and 400 at user level, probe the threshold. A design that ignores the level or compares with the wrong sign would send those traps to the hypervisor. The bench unwinds the whole stack and checks every restored field. A design that let an error stop write the stack, or that dropped the saturating RED overwrite, would return the wrong PC and state words. The bench also covers a return at level zero and a trap colliding with a return, where a faulty design would underflow the level or raise a false `ret_vld`.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        DEST_PRIV  = 2'd0,
        DEST_HYPER = 2'd1,
        DEST_RED   = 2'd2,
        DEST_ERROR = 2'd3
    } dest_e;

    localparam logic [1:0] LVL_USER = 2'd0;
    localparam logic [1:0] LVL_PRIV = 2'd1;

    localparam int HP_RED_BIT   = 5;
    localparam int RED_VEC_IDX  = 5;
    localparam int WDOG_VEC_IDX = 2;
    localparam int HYP_TT_FLOOR = 384;

    localparam int ASI_LSB = 24;
    localparam int CCR_LSB = 32;
    localparam int GL_LSB  = 40;
    localparam int BYTE_W  = 8;
    localparam int GL_W    = 3;

    function automatic logic lvl_is_hyper(input logic [1:0] lvl);
        return lvl[1];
    endfunction

endpackage

// File: rtl/tlc_route.sv
module tlc_route
    import tlc_pkg::*;
#(
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2,
    parameter int TLW     = 3,
    parameter int TTW     = 9
) (
    input  logic [TLW-1:0] tl,
    input  logic [1:0]     lvl,
    input  logic           red_req,
    input  logic [TTW-1:0] tt,
    output dest_e          dest,
    output logic [TTW-1:0] vec,
    output logic [TLW-1:0] tl_new,
    output logic           push
);
    localparam logic [TLW-1:0] TL_TOP  = TLW'(MAX_TL);
    localparam logic [TLW-1:0] TL_NEAR = TLW'(MAX_TL - 1);
    localparam logic [TLW-1:0] TL_PTOP = TLW'(MAX_PTL);

    logic [TLW-1:0] tl_up;
    logic           tt_forces_hyp;

    assign tl_up         = (tl == TL_TOP) ? tl : tl + TLW'(1);
    assign tt_forces_hyp = (32'(tt) >= HYP_TT_FLOOR);

    always_comb begin
        dest   = DEST_PRIV;
        vec    = tt;
        tl_new = tl_up;
        push   = 1'b1;
        if (red_req || tl == TL_NEAR) begin
            dest = DEST_RED;
            vec  = TTW'(RED_VEC_IDX);
        end else if (tl == TL_TOP) begin
            dest   = DEST_ERROR;
            vec    = '0;
            tl_new = tl;
            push   = 1'b0;
        end else if (lvl == LVL_PRIV && tl > TL_PTOP) begin
            dest = DEST_HYPER;
            vec  = TTW'(WDOG_VEC_IDX);
        end else if (lvl_is_hyper(lvl) || (lvl == LVL_PRIV && tt_forces_hyp)) begin
            dest = DEST_HYPER;
        end
    end
endmodule

// File: rtl/tlc_stack.sv
module tlc_stack #(
    parameter int DEPTH = 6,
    parameter int TLW   = 3,
    parameter int EW    = 156
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [TLW-1:0] wr_idx,
    input  logic [EW-1:0]  wr_data,
    input  logic [TLW-1:0] rd_idx,
    output logic [EW-1:0]  rd_data
);
    logic [EW-1:0] slot_q [1:DEPTH];

    for (genvar s = 1; s <= DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[s] <= '0;
            end else if (wr_en && wr_idx == TLW'(s)) begin
                slot_q[s] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int s = 1; s <= DEPTH; s++) begin
            if (rd_idx == TLW'(s)) rd_data = slot_q[s];
        end
    end
endmodule

// File: rtl/tlc_trap_ctrl.sv
module tlc_trap_ctrl
    import tlc_pkg::*;
#(
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2,
    parameter int TTW     = 9,
    parameter int PCW     = 48,
    parameter int TSW     = 48,
    parameter int HPW     = 12,
    localparam int TLW    = $clog2(MAX_TL + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           trap_req,
    input  logic [TTW-1:0] trap_type,
    input  logic [1:0]     priv_lvl,
    input  logic [HPW-1:0] hpstate,
    input  logic [PCW-1:0] cur_pc,
    input  logic [PCW-1:0] cur_npc,
    input  logic [TSW-1:0] cur_tstate,
    input  logic           ret_req,
    output logic [TLW-1:0] tl,
    output logic           trap_vld,
    output logic [1:0]     trap_dest,
    output logic [TTW-1:0] trap_vec,
    output logic           ret_vld,
    output logic [7:0]     ret_asi,
    output logic [7:0]     ret_ccr,
    output logic [2:0]     ret_gl,
    output logic [HPW-1:0] ret_hpstate,
    output logic [PCW-1:0] ret_npc,
    output logic [PCW-1:0] ret_nnpc
);
    localparam int EW = HPW + TSW + 2 * PCW;

    logic [TLW-1:0] tl_q;
    dest_e          rt_dest;
    logic [TTW-1:0] rt_vec;
    logic [TLW-1:0] rt_tl;
    logic           rt_push;
    logic [EW-1:0]  push_word;
    logic [EW-1:0]  top_word;

    logic [PCW-1:0] sv_pc;
    logic [PCW-1:0] sv_npc;
    logic [TSW-1:0] sv_ts;
    logic [HPW-1:0] sv_hp;

    tlc_route #(
        .MAX_TL (MAX_TL),
        .MAX_PTL(MAX_PTL),
        .TLW    (TLW),
        .TTW    (TTW)
    ) u_route (
        .tl     (tl_q),
        .lvl    (priv_lvl),
        .red_req(hpstate[HP_RED_BIT]),
        .tt     (trap_type),
        .dest   (rt_dest),
        .vec    (rt_vec),
        .tl_new (rt_tl),
        .push   (rt_push)
    );

    assign push_word = {hpstate, cur_tstate, cur_npc, cur_pc};

    tlc_stack #(
        .DEPTH(MAX_TL),
        .TLW  (TLW),
        .EW   (EW)
    ) u_stack (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (trap_req && rt_push),
        .wr_idx (rt_tl),
        .wr_data(push_word),
        .rd_idx (tl_q),
        .rd_data(top_word)
    );

    assign {sv_hp, sv_ts, sv_npc, sv_pc} = top_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            tl_q        <= '0;
            trap_vld    <= 1'b0;
            trap_dest   <= DEST_PRIV;
            trap_vec    <= '0;
            ret_vld     <= 1'b0;
            ret_asi     <= '0;
            ret_ccr     <= '0;
            ret_gl      <= '0;
            ret_hpstate <= '0;
            ret_npc     <= '0;
            ret_nnpc    <= '0;
        end else begin
            trap_vld <= trap_req;
            ret_vld  <= 1'b0;
            if (trap_req) begin
                trap_dest <= rt_dest;
                trap_vec  <= rt_vec;
                tl_q      <= rt_tl;
            end else if (ret_req && tl_q != '0) begin
                ret_vld     <= 1'b1;
                ret_asi     <= sv_ts[ASI_LSB +: BYTE_W];
                ret_ccr     <= sv_ts[CCR_LSB +: BYTE_W];
                ret_gl      <= sv_ts[GL_LSB +: GL_W];
                ret_hpstate <= sv_hp;
                ret_npc     <= sv_pc;
                ret_nnpc    <= sv_npc;
                tl_q        <= tl_q - TLW'(1);
            end
        end
    end

    assign tl = tl_q;
endmodule

// File: rtl/tlc_trap_ctrl_chk.sv
module tlc_trap_ctrl_chk #(
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2,
    parameter int TTW     = 9,
    parameter int HPW     = 12,
    localparam int TLW    = $clog2(MAX_TL + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           trap_req,
    input logic           ret_req,
    input logic [1:0]     priv_lvl,
    input logic [HPW-1:0] hpstate,
    input logic [TTW-1:0] trap_type,
    input logic [TLW-1:0] tl,
    input logic           trap_vld,
    input logic [1:0]     trap_dest,
    input logic [TTW-1:0] trap_vec,
    input logic           ret_vld
);
    localparam logic [TLW-1:0] TL_TOP  = TLW'(MAX_TL);
    localparam logic [TLW-1:0] TL_NEAR = TLW'(MAX_TL - 1);
    localparam logic [TLW-1:0] TL_PTOP = TLW'(MAX_PTL);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tl == '0 && !trap_vld && !ret_vld));

    a_r2_red_entry: assert property (@(posedge clk) disable iff (rst)
        (trap_req && hpstate[5]) |=> (trap_dest == 2'd2 && trap_vec == TTW'(5)));

    a_r3_error_stop: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !hpstate[5] && tl == TL_TOP) |=> (trap_dest == 2'd3 && $stable(tl)));

    a_r4_guest_wdog: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !hpstate[5] && tl < TL_NEAR && priv_lvl == 2'd1 && tl > TL_PTOP)
        |=> (trap_dest == 2'd1 && trap_vec == TTW'(2)));

    a_r5_hyper_level: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !hpstate[5] && tl < TL_NEAR && priv_lvl[1])
        |=> (trap_dest == 2'd1 && trap_vec == $past(trap_type)));

    a_r6_user_priv: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !hpstate[5] && tl < TL_NEAR && priv_lvl == 2'd0)
        |=> (trap_dest == 2'd0 && trap_vec == $past(trap_type)));

    a_r7_level_up: assert property (@(posedge clk) disable iff (rst)
        (trap_req && tl < TL_NEAR) |=> (trap_vld && tl == $past(tl) + TLW'(1)));

    a_r9_level_down: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !trap_req && tl != '0) |=> (ret_vld && tl == $past(tl) - TLW'(1)));

    a_r10_ret_at_zero: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !trap_req && tl == '0) |=> (!ret_vld && tl == '0));

    a_r11_trap_wins: assert property (@(posedge clk) disable iff (rst)
        (ret_req && trap_req) |=> (!ret_vld && trap_vld));
endmodule

bind tlc_trap_ctrl tlc_trap_ctrl_chk #(
    .MAX_TL (MAX_TL),
    .MAX_PTL(MAX_PTL),
    .TTW    (TTW),
    .HPW    (HPW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trap_req (trap_req),
    .ret_req  (ret_req),
    .priv_lvl (priv_lvl),
    .hpstate  (hpstate),
    .trap_type(trap_type),
    .tl       (tl),
    .trap_vld (trap_vld),
    .trap_dest(trap_dest),
    .trap_vec (trap_vec),
    .ret_vld  (ret_vld)
);

// File: tb/tlc_trap_ctrl_tb.sv
`timescale 1ns/1ps
module tlc_trap_ctrl_tb;
    localparam int MAX_TL = 6;
    localparam int TTW = 9;
    localparam int PCW = 48;
    localparam int TSW = 48;
    localparam int HPW = 12;
    localparam int TLW = 3;

    // {lvl[25:24], red[23], tt[22:14], dest[13:12], vec[11:3], tl[2:0]}
    localparam int NTBL = 7;
    localparam logic [25:0] TBL [0:NTBL-1] = '{
        {2'd0, 1'b0, 9'h010, 2'd0, 9'h010, 3'd1},  // R6 user default
        {2'd1, 1'b0, 9'h020, 2'd0, 9'h020, 3'd2},  // R6 priv below limits
        {2'd1, 1'b0, 9'h180, 2'd1, 9'h180, 3'd3},  // R5 type 384 at priv
        {2'd1, 1'b0, 9'h030, 2'd1, 9'h002, 3'd4},  // R4 watchdog tl 3 > 2
        {2'd2, 1'b0, 9'h041, 2'd1, 9'h041, 3'd5},  // R5 hyper level
        {2'd0, 1'b0, 9'h050, 2'd2, 9'h005, 3'd6},  // R2 tl = MAX_TL-1
        {2'd2, 1'b0, 9'h060, 2'd3, 9'h000, 3'd6}   // R3 error at MAX_TL
    };

    logic clk = 1'b0;
    logic rst;
    logic trap_req, ret_req;
    logic [TTW-1:0] trap_type;
    logic [1:0] priv_lvl;
    logic [HPW-1:0] hpstate;
    logic [PCW-1:0] cur_pc, cur_npc;
    logic [TSW-1:0] cur_tstate;
    logic [TLW-1:0] tl;
    logic trap_vld, ret_vld;
    logic [1:0] trap_dest;
    logic [TTW-1:0] trap_vec;
    logic [7:0] ret_asi, ret_ccr;
    logic [2:0] ret_gl;
    logic [HPW-1:0] ret_hpstate;
    logic [PCW-1:0] ret_npc, ret_nnpc;

    always #2.5 clk = ~clk;

    tlc_trap_ctrl u_dut (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_type(trap_type),
        .priv_lvl(priv_lvl), .hpstate(hpstate), .cur_pc(cur_pc), .cur_npc(cur_npc),
        .cur_tstate(cur_tstate), .ret_req(ret_req), .tl(tl), .trap_vld(trap_vld),
        .trap_dest(trap_dest), .trap_vec(trap_vec), .ret_vld(ret_vld),
        .ret_asi(ret_asi), .ret_ccr(ret_ccr), .ret_gl(ret_gl),
        .ret_hpstate(ret_hpstate), .ret_npc(ret_npc), .ret_nnpc(ret_nnpc)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int seq = 0;

    logic [PCW-1:0] m_pc  [1:MAX_TL];
    logic [PCW-1:0] m_npc [1:MAX_TL];
    logic [TSW-1:0] m_ts  [1:MAX_TL];
    logic [HPW-1:0] m_hp  [1:MAX_TL];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one trap; sample results one cycle later; push model slot if expected.
    task automatic do_trap(input string req, input logic [1:0] lvl, input logic red,
                           input logic [TTW-1:0] tt, input logic with_ret,
                           input logic [1:0] e_dest, input logic [TTW-1:0] e_vec,
                           input logic [TLW-1:0] e_tl);
        logic [PCW-1:0] pc;
        pc = 48'h4000_0000 + 48'(seq) * 48'h20;
        @(negedge clk);
        trap_req   = 1'b1;
        ret_req    = with_ret;
        priv_lvl   = lvl;
        trap_type  = tt;
        hpstate    = {4'h3, 2'b00, red, 5'(seq)};
        cur_pc     = pc;
        cur_npc    = pc + 48'd4;
        cur_tstate = {5'd0, 3'(seq), 8'(8'hC0 + seq), 8'(8'hA0 + seq), 24'h5A5A00 + 24'(seq)};
        if (e_dest != 2'd3) begin
            m_pc[e_tl]  = cur_pc;
            m_npc[e_tl] = cur_npc;
            m_ts[e_tl]  = cur_tstate;
            m_hp[e_tl]  = hpstate;
        end
        seq++;
        @(posedge clk);
        @(negedge clk);
        trap_req = 1'b0;
        ret_req  = 1'b0;
        chk(trap_vld && trap_dest == e_dest && trap_vec == e_vec && tl == e_tl, req,
            {50'd0, trap_dest, trap_vec, tl}, {50'd0, e_dest, e_vec, e_tl});
        if (with_ret) chk(!ret_vld, "R11 return dropped", 64'(ret_vld), 64'd0);
    endtask

    task automatic do_ret(input string req);
        logic [TLW-1:0] t0;
        logic [TSW-1:0] ts;
        t0 = tl;
        ts = m_ts[t0];
        @(negedge clk);
        ret_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ret_req = 1'b0;
        chk(ret_vld && tl == t0 - 3'd1 && ret_asi == ts[31:24] && ret_ccr == ts[39:32]
            && ret_gl == ts[42:40] && ret_hpstate == m_hp[t0], req,
            {33'd0, ret_vld, ret_gl, ret_ccr, ret_asi, ret_hpstate, tl},
            {33'd0, 1'b1, ts[42:40], ts[39:32], ts[31:24], m_hp[t0], t0 - 3'd1});
        chk(ret_npc == m_pc[t0] && ret_nnpc == m_npc[t0], req,
            {ret_npc[31:0], ret_nnpc[31:0]}, {m_pc[t0][31:0], m_npc[t0][31:0]});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; trap_req = 1'b0; ret_req = 1'b0; trap_type = '0; priv_lvl = '0;
        hpstate = '0; cur_pc = '0; cur_npc = '0; cur_tstate = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tl == 0 && !trap_vld && !ret_vld, "R1 reset state",
            {59'd0, trap_vld, ret_vld, tl}, 64'd0);
        rst = 1'b0;

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NTBL; i++) begin
            do_trap("R7 table route", TBL[i][25:24], TBL[i][23], TBL[i][22:14], 1'b0,
                    TBL[i][13:12], TBL[i][11:3], TBL[i][2:0]);
        end

        // Unwind: R9 restore, R8 slot contents, R3 (error wrote no slot)
        for (int i = 0; i < MAX_TL; i++) do_ret("R9 R8 R3 unwind");

        // R10 return at level zero
        @(negedge clk);
        ret_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ret_req = 1'b0;
        chk(!ret_vld && tl == 0, "R10 return at zero", {60'd0, ret_vld, tl}, 64'd0);

        // R11 trap and return together
        do_trap("R11 trap wins", 2'd0, 1'b0, 9'h022, 1'b1, 2'd0, 9'h022, 3'd1);
        // R5 boundary: type 383 at priv stays privileged
        do_trap("R5 type 383 priv", 2'd1, 1'b0, 9'h17F, 1'b0, 2'd0, 9'h17F, 3'd2);
        // R4 boundary: tl == MAX_PTL is no watchdog
        do_trap("R4 tl at MAX_PTL", 2'd1, 1'b0, 9'h033, 1'b0, 2'd0, 9'h033, 3'd3);
        // R6 user with type 400
        do_trap("R6 user high type", 2'd0, 1'b0, 9'h190, 1'b0, 2'd0, 9'h190, 3'd4);
        // R2 red bit at low level
        do_trap("R2 red bit", 2'd2, 1'b1, 9'h044, 1'b0, 2'd2, 9'h005, 3'd5);
        // R2 near-limit from hyper
        do_trap("R2 near limit", 2'd2, 1'b0, 9'h045, 1'b0, 2'd2, 9'h005, 3'd6);
        // R2 red bit at MAX_TL saturates and overwrites the top slot
        do_trap("R2 saturate", 2'd0, 1'b1, 9'h046, 1'b0, 2'd2, 9'h005, 3'd6);
        do_ret("R8 overwritten top slot");

        // R1 reset from a busy state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(tl == 0 && !trap_vld && !ret_vld, "R1 reset mid run",
            {59'd0, trap_vld, ret_vld, tl}, 64'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule